// File: doc/BRIEF.md
# Chaotic-Stage Bit Harvester and Debiasing Post-Processor

This block sits beside a ring of 1.5-bit pipeline converter stages that run as chaotic maps. Each stage hands over its two comparator decisions; the block folds every pair into one raw random bit with an XOR, which merges the four map intervals into two equally likely macro-states. Even-numbered stages settle on one clock phase and odd-numbered stages on the other. The block therefore samples the odd group on the falling edge, holds it, and moves it into the rising-edge domain together with the even group. From there on, all logic runs on the rising edge.

The raw bits of one cycle form a stream with stage 0 first. A runtime mode picks what is done with that stream. It can be passed through unchanged, fed to a pair-based Von Neumann corrector, reduced by XOR over groups of four, or discarded. Pair and group boundaries carry over from one cycle to the next. Because the number of bits produced varies from cycle to cycle, finished bits collect in a small bit FIFO. They leave as bytes under a valid/ready handshake, and a sticky flag reports any bits lost while the consumer stalls.

Top module: `chaos_harvest`

## Requirements
- R1: The raw bit of stage i is the XOR of `stage_cmp_i[2i+1]` and `stage_cmp_i[2i]`.
- R2: Even-indexed stage pairs are sampled on a rising clock edge. Odd-indexed pairs are sampled on the falling edge just before that rising edge. Pair values at any other time have no effect on the output.
- R3: The raw bits of one cycle form a stream with stage 0 first. Output bits leave in stream order, and within `out_data_o` bit 0 carries the earliest bit. The word sampled at rising edge k is processed at rising edge k+1, using the `mode_i` value present at that edge.
- R4: In mode 0 (pass) every raw bit becomes one output bit.
- R5: In mode 1 (Von Neumann) the stream is cut into non-overlapping pairs, first bit then second, and the pairs continue across cycles. A pair 0,1 yields 0, a pair 1,0 yields 1, and pairs 0,0 and 1,1 yield nothing.
- R6: In mode 2 (parity) each non-overlapping group of four stream bits yields one bit equal to their XOR, and the groups continue across cycles.
- R7: In mode 3 (halt) no output bits are produced.
- R8: When `mode_i` differs from its value at the previous edge, any partial pair or group is discarded. No output bit mixes raw bits from two modes.
- R9: When `clr_i` is high at an edge, the FIFO, the partial pair or group, and `ovf_o` are cleared, and the word processed at that edge is discarded.
- R10: `out_vld_o` is high while at least 8 bits are held. The byte stays stable until `out_rdy_i` accepts it.
- R11: If the bits produced at an edge do not fit in the space left after that edge's read, all of them are dropped and `ovf_o` is set. `ovf_o` stays set until `clr_i` or reset.
- R12: During and right after reset `out_vld_o` and `ovf_o` are low. The first rising edge after reset only samples and produces no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock; both edges are used for capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of FIFO, partial state and overflow flag |
| mode_i | input | 2 | 0 pass, 1 Von Neumann, 2 parity of four, 3 halt |
| stage_cmp_i | input | 2*NSTG | Comparator pair of stage i at bits 2i+1:2i |
| out_data_o | output | OUT_W | Output byte, bit 0 earliest |
| out_vld_o | output | 1 | Output byte available |
| out_rdy_i | input | 1 | Consumer accepts the byte at this edge |
| ovf_o | output | 1 | Sticky flag: output bits were dropped |

## Verification
Writing new bits into the FIFO and reading a byte out of it can happen on the same edge, and the overflow decision depends on the space the read frees in that edge. The bench provokes this in two ways. It holds the ready input low in pass mode until the FIFO fills, and it toggles ready at random while the corrector emits a varying number of bits. A reference model of occupancy, written from the requirements, predicts each byte and each change of the overflow flag. A second instance with six stages leaves parity groups split across cycles, so that mode changes actually discard partial state.

// File: rtl/chaos_harvest_pkg.sv
package chaos_harvest_pkg;
  typedef enum logic [1:0] {
    DBM_PASS = 2'd0,
    DBM_VN   = 2'd1,
    DBM_PAR  = 2'd2,
    DBM_HALT = 2'd3
  } dbm_e;
endpackage

// File: rtl/chaos_phase_capture.sv
// Two-phase capture of the stage comparator pairs and XOR aggregation.
module chaos_phase_capture #(
  parameter int NSTG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NSTG-1:0] cmp_i,
  output logic [NSTG-1:0]   raw_o,
  output logic              raw_vld_o
);

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    logic [1:0] pair_q;
    if ((g % 2) == 0) begin : g_even
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= 2'b00;
        else        pair_q <= cmp_i[2*g +: 2];
      end
    end else begin : g_odd
      logic [1:0] hold_q;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 2'b00;
        else        hold_q <= cmp_i[2*g +: 2];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pair_q <= 2'b00;
        else        pair_q <= hold_q;
      end
    end
    assign raw_o[g] = pair_q[1] ^ pair_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_vld_o <= 1'b0;
    else        raw_vld_o <= 1'b1;
  end

endmodule

// File: rtl/chaos_debias.sv
// Mode-selected post-processor with partial pair/group carried across cycles.
module chaos_debias
  import chaos_harvest_pkg::*;
#(
  parameter int NSTG = 8,
  localparam int CW  = $clog2(NSTG + 1),
  localparam int SW  = NSTG + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  dbm_e            mode_i,
  input  logic [NSTG-1:0] raw_i,
  input  logic            raw_vld_i,
  output logic [NSTG-1:0] bits_o,
  output logic [CW-1:0]   nbits_o
);

  dbm_e        mode_q;
  logic [2:0]  pend_q, pend_n;
  logic [1:0]  pcnt_q, pcnt_n;
  logic [NSTG-1:0] bits_n;
  logic [SW-1:0]   strm;
  logic [1:0]  pc;
  logic        keep;
  int          len;
  int          k;
  int          rem;

  always_comb begin
    keep   = (mode_i == mode_q);
    pc     = keep ? pcnt_q : 2'd0;
    strm   = ({3'b000, raw_i} << pc) | SW'(keep ? pend_q : 3'b000);
    len    = NSTG + int'(pc);
    rem    = 0;
    k      = 0;
    bits_n = '0;
    pend_n = 3'b000;
    pcnt_n = 2'd0;
    if (clr_i) begin
      k = 0;
    end else if (!raw_vld_i) begin
      pend_n = pend_q;
      pcnt_n = pcnt_q;
    end else begin
      case (mode_i)
        DBM_PASS: begin
          bits_n = raw_i;
          k      = NSTG;
        end
        DBM_VN: begin
          for (int j = 0; j < SW / 2; j++) begin
            if ((2*j + 1 < len) && (strm[2*j] != strm[2*j+1])) begin
              for (int q = 0; q < NSTG; q++) begin
                if (q == k) bits_n[q] = strm[2*j];
              end
              k = k + 1;
            end
          end
          if ((len % 2) == 1) begin
            for (int p = 0; p < SW; p++) begin
              if (p == len - 1) pend_n[0] = strm[p];
            end
            pcnt_n = 2'd1;
          end
        end
        DBM_PAR: begin
          for (int j = 0; j < SW / 4; j++) begin
            if (4*j + 3 < len) begin
              for (int q = 0; q < NSTG; q++) begin
                if (q == k) bits_n[q] = ^strm[4*j +: 4];
              end
              k = k + 1;
            end
          end
          rem    = len % 4;
          pcnt_n = 2'(rem);
          for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < SW; p++) begin
              if ((b < rem) && (p == len - rem + b)) pend_n[b] = strm[p];
            end
          end
        end
        default: k = 0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= DBM_PASS;
      pend_q  <= 3'b000;
      pcnt_q  <= 2'd0;
    end else begin
      mode_q  <= mode_i;
      pend_q  <= pend_n;
      pcnt_q  <= pcnt_n;
    end
  end

  assign bits_o  = bits_n;
  assign nbits_o = CW'(k);

endmodule

// File: rtl/chaos_bit_fifo.sv
// Bit FIFO: up to WIN bits written per cycle, OUT_W bits read per accepted word.
module chaos_bit_fifo #(
  parameter int WIN   = 8,
  parameter int DEPTH = 32,
  parameter int OUT_W = 8,
  localparam int CW   = $clog2(WIN + 1),
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [WIN-1:0]   wr_bits_i,
  input  logic [CW-1:0]    wr_n_i,
  input  logic             rd_rdy_i,
  output logic [OUT_W-1:0] rd_data_o,
  output logic             rd_vld_o,
  output logic             ovf_o
);

  logic [DEPTH-1:0] mem_q, mem_n;
  logic [AW-1:0]    wr_q, wr_n, rd_q, rd_n;
  logic [FW-1:0]    cnt_q, cnt_n, free;
  logic             ovf_n, pop, push, drop;

  assign rd_vld_o = (cnt_q >= FW'(OUT_W));

  always_comb begin
    for (int b = 0; b < OUT_W; b++) rd_data_o[b] = mem_q[rd_q + AW'(b)];
  end

  always_comb begin
    pop   = rd_vld_o && rd_rdy_i;
    free  = FW'(DEPTH) - cnt_q + (pop ? FW'(OUT_W) : FW'(0));
    push  = (wr_n_i != '0) && (FW'(wr_n_i) <= free);
    drop  = (wr_n_i != '0) && !(FW'(wr_n_i) <= free);
    mem_n = mem_q;
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    ovf_n = ovf_q_or(drop);
    if (clr_i) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
      ovf_n = 1'b0;
    end else begin
      if (push) begin
        for (int b = 0; b < WIN; b++) begin
          if (CW'(b) < wr_n_i) mem_n[wr_q + AW'(b)] = wr_bits_i[b];
        end
        wr_n = wr_q + AW'(wr_n_i);
      end
      if (pop) rd_n = rd_q + AW'(OUT_W);
      cnt_n = cnt_q - (pop ? FW'(OUT_W) : FW'(0)) + (push ? FW'(wr_n_i) : FW'(0));
    end
  end

  function automatic logic ovf_q_or(input logic d);
    return ovf_o | d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      mem_q <= mem_n;
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
      ovf_o <= ovf_n;
    end
  end

endmodule

// File: rtl/chaos_harvest.sv
module chaos_harvest
  import chaos_harvest_pkg::*;
#(
  parameter int NSTG       = 8,
  parameter int FIFO_DEPTH = 32,
  parameter int OUT_W      = 8,
  localparam int CW        = $clog2(NSTG + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [1:0]        mode_i,
  input  logic [2*NSTG-1:0] stage_cmp_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_vld_o,
  input  logic              out_rdy_i,
  output logic              ovf_o
);

  logic [NSTG-1:0] raw;
  logic            raw_vld;
  logic [NSTG-1:0] dbits;
  logic [CW-1:0]   dcnt;

  chaos_phase_capture #(.NSTG(NSTG)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_i     (stage_cmp_i),
    .raw_o     (raw),
    .raw_vld_o (raw_vld)
  );

  chaos_debias #(.NSTG(NSTG)) u_dbs (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .mode_i    (dbm_e'(mode_i)),
    .raw_i     (raw),
    .raw_vld_i (raw_vld),
    .bits_o    (dbits),
    .nbits_o   (dcnt)
  );

  chaos_bit_fifo #(.WIN(NSTG), .DEPTH(FIFO_DEPTH), .OUT_W(OUT_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .wr_bits_i (dbits),
    .wr_n_i    (dcnt),
    .rd_rdy_i  (out_rdy_i),
    .rd_data_o (out_data_o),
    .rd_vld_o  (out_vld_o),
    .ovf_o     (ovf_o)
  );

endmodule

// File: rtl/chaos_harvest_chk.sv
module chaos_harvest_chk #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_i,
  input logic [1:0]       mode_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             out_vld_o,
  input logic             out_rdy_i,
  input logic             ovf_o
);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_i) |=> ovf_o);

  assert_ovf_needs_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(!out_rdy_i));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!out_vld_o && !ovf_o));

  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld_o && !out_rdy_i && !clr_i) |=> (out_vld_o && $stable(out_data_o)));

  assert_halt_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd3 && !out_vld_o) |=> !out_vld_o);

endmodule

bind chaos_harvest chaos_harvest_chk #(.OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .mode_i     (mode_i),
  .out_data_o (out_data_o),
  .out_vld_o  (out_vld_o),
  .out_rdy_i  (out_rdy_i),
  .ovf_o      (ovf_o)
);

// File: tb/chaos_harvest_bench.sv
// Scoreboard: reference model fed from the pins, monitor compares output bytes.
module chaos_harvest_sb #(
  parameter int N     = 8,
  parameter int DEPTH = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] cmp,
  input logic [1:0]     mode,
  input logic           clr,
  input logic           rdy,
  input logic [7:0]     dout,
  input logic           dvld,
  input logic           ovf
);
  int    n_chk  = 0;
  int    n_fail = 0;
  string req    = "R12";
  bit    expq[$];
  bit    pend[$];
  bit    s[$];
  bit    outb[$];
  bit    exp_ovf;
  bit    cap_ok;
  logic [N-1:0] capw;
  logic [N-1:0] oddh;
  logic [1:0]   lastm;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 1; i < N; i += 2) oddh[i] = ^cmp[2*i +: 2];
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expq.delete(); pend.delete();
      exp_ovf = 0; cap_ok = 0; lastm = 2'd0;
    end else begin
      if (clr) begin
        expq.delete(); pend.delete(); exp_ovf = 0;
      end else if (cap_ok) begin
        if (mode != lastm) pend.delete();
        s = pend; pend.delete(); outb.delete();
        for (int i = 0; i < N; i++) s.push_back(capw[i]);
        case (mode)
          2'd0: foreach (s[i]) outb.push_back(s[i]);
          2'd1: begin
            for (int j = 0; j + 1 < s.size(); j += 2)
              if (s[j] != s[j+1]) outb.push_back(s[j]);
            if (s.size() % 2 == 1) pend.push_back(s[s.size()-1]);
          end
          2'd2: begin
            int g;
            g = s.size() / 4;
            for (int j = 0; j < g; j++)
              outb.push_back(s[4*j] ^ s[4*j+1] ^ s[4*j+2] ^ s[4*j+3]);
            for (int j = 4*g; j < s.size(); j++) pend.push_back(s[j]);
          end
          default: ;
        endcase
        if (outb.size() > DEPTH - expq.size()) exp_ovf = 1;
        else foreach (outb[i]) expq.push_back(outb[i]);
      end
      lastm = mode;
      for (int i = 0; i < N; i += 2) capw[i] = ^cmp[2*i +: 2];
      for (int i = 1; i < N; i += 2) capw[i] = oddh[i];
      cap_ok = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (ovf !== exp_ovf) begin
        n_fail++;
        $display("FAIL %s/R11 N=%0d ovf actual %b expected %b", req, N, ovf, exp_ovf);
      end
      n_chk++;
      if (dvld !== (expq.size() >= 8)) begin
        n_fail++;
        $display("FAIL %s/R10 N=%0d out_vld actual %b expected %b", req, N, dvld, expq.size() >= 8);
      end
      if (rdy && expq.size() >= 8) begin
        logic [7:0] e;
        for (int b = 0; b < 8; b++) e[b] = expq.pop_front();
        n_chk++;
        if (dout !== e) begin
          n_fail++;
          $display("FAIL %s N=%0d out_data actual %h expected %h", req, N, dout, e);
        end
      end
    end
  end
endmodule

module chaos_harvest_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [1:0]  mode;
  logic        rdy;
  logic [15:0] cmp8;
  logic [11:0] cmp6;
  logic [7:0]  d8, d6;
  logic        v8, v6, o8, o6;
  int          b_chk  = 0;
  int          b_fail = 0;
  bit          done   = 0;

  always #4 clk = ~clk;

  chaos_harvest u_chaos_harvest (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .mode_i(mode), .stage_cmp_i(cmp8),
    .out_data_o(d8), .out_vld_o(v8), .out_rdy_i(rdy), .ovf_o(o8));

  chaos_harvest #(.NSTG(6), .FIFO_DEPTH(16)) u_chaos_harvest_n6 (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .mode_i(mode), .stage_cmp_i(cmp6),
    .out_data_o(d6), .out_vld_o(v6), .out_rdy_i(rdy), .ovf_o(o6));

  chaos_harvest_sb #(.N(8), .DEPTH(32)) u_sb8 (
    .clk(clk), .rst_n(rst_n), .cmp(cmp8), .mode(mode), .clr(clr), .rdy(rdy),
    .dout(d8), .dvld(v8), .ovf(o8));

  chaos_harvest_sb #(.N(6), .DEPTH(16)) u_sb6 (
    .clk(clk), .rst_n(rst_n), .cmp(cmp6), .mode(mode), .clr(clr), .rdy(rdy),
    .dout(d6), .dvld(v6), .ovf(o6));

  function automatic logic [1:0] mkpair(input logic r);
    logic x;
    x = 1'($urandom);
    return {r ^ x, x};
  endfunction

  // Driver: odd pairs right in the first half, even pairs right in the second;
  // the other group carries a pair of the opposite XOR (R2).
  task automatic drive(input logic [7:0] w8, input logic [5:0] w6);
    logic [15:0] good8;
    logic [11:0] good6;
    for (int i = 0; i < 8; i++) good8[2*i +: 2] = mkpair(w8[i]);
    for (int i = 0; i < 6; i++) good6[2*i +: 2] = mkpair(w6[i]);
    for (int i = 0; i < 8; i++) cmp8[2*i +: 2] = (i % 2) ? good8[2*i +: 2] : good8[2*i +: 2] ^ 2'b01;
    for (int i = 0; i < 6; i++) cmp6[2*i +: 2] = (i % 2) ? good6[2*i +: 2] : good6[2*i +: 2] ^ 2'b01;
    @(negedge clk); #1;
    for (int i = 0; i < 8; i++) cmp8[2*i +: 2] = (i % 2) ? good8[2*i +: 2] ^ 2'b10 : good8[2*i +: 2];
    for (int i = 0; i < 6; i++) cmp6[2*i +: 2] = (i % 2) ? good6[2*i +: 2] ^ 2'b10 : good6[2*i +: 2];
    @(posedge clk); #1;
  endtask

  task automatic step();
    drive(8'($urandom), 6'($urandom));
  endtask

  task automatic set_req(input string r);
    u_sb8.req = r;
    u_sb6.req = r;
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; mode = 2'd0; rdy = 1'b1; cmp8 = '0; cmp6 = '0;
    repeat (3) @(posedge clk);
    #1;
    b_chk++;
    if (v8 !== 1'b0 || o8 !== 1'b0 || v6 !== 1'b0 || o6 !== 1'b0) begin
      b_fail++;
      $display("FAIL R12 reset outputs actual %b%b%b%b expected 0000", v8, o8, v6, o6);
    end
    rst_n = 1'b1;
    set_req("R2");
    drive(8'hA5, 6'h2D); drive(8'h3C, 6'h12); drive(8'hFF, 6'h00); drive(8'h01, 6'h3F);
    set_req("R4");
    repeat (12) step();
    set_req("R3");
    drive(8'h80, 6'h20); drive(8'h00, 6'h01);
    set_req("R5");
    mode = 2'd1;
    repeat (40) step();
    set_req("R6");
    mode = 2'd2;
    repeat (40) step();
    set_req("R8");
    for (int n = 0; n < 40; n++) begin
      mode = 2'($urandom_range(2, 0));
      step();
    end
    set_req("R7");
    mode = 2'd3;
    repeat (10) step();
    set_req("R11");
    mode = 2'd0; rdy = 1'b0;
    repeat (6) step();
    b_chk++;
    if (o8 !== 1'b1 || o6 !== 1'b1) begin
      b_fail++;
      $display("FAIL R11 ovf after stall actual %b%b expected 11", o8, o6);
    end
    mode = 2'd3; rdy = 1'b1;
    repeat (8) step();
    set_req("R9");
    clr = 1'b1;
    step();
    clr = 1'b0;
    b_chk++;
    if (o8 !== 1'b0 || o6 !== 1'b0 || v8 !== 1'b0 || v6 !== 1'b0) begin
      b_fail++;
      $display("FAIL R9 after clear actual %b%b%b%b expected 0000", o8, o6, v8, v6);
    end
    mode = 2'd2;
    repeat (10) step();
    set_req("R10");
    mode = 2'd1;
    for (int n = 0; n < 60; n++) begin
      rdy = 1'($urandom);
      if (n % 15 == 7) mode = 2'($urandom_range(2, 0));
      step();
    end
    set_req("R1");
    mode = 2'd0; rdy = 1'b1;
    repeat (10) step();
    mode = 2'd3;
    repeat (10) step();
    done = 1;
    b_chk  += u_sb8.n_chk + u_sb6.n_chk;
    b_fail += u_sb8.n_fail + u_sb6.n_fail;
    $display("End of test - %0d assertions evaluated, %0d failures", b_chk, b_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      b_fail++;
      $display("FAIL R12 watchdog actual running expected finished");
      b_chk  += u_sb8.n_chk + u_sb6.n_chk;
      b_fail += u_sb8.n_fail + u_sb6.n_fail;
      $display("End of test - %0d assertions evaluated, %0d failures", b_chk, b_fail);
      $finish;
    end
  end
endmodule